// File: doc/BRIEF.md
# Slot-Based Multichannel Power Sequencer

This block drives twelve supply-enable outputs through four timed orderings: power up, power down, sleep entry and sleep exit. Each ordering has its own table that gives every output a 4-bit slot index. A sequence walks sixteen slots in turn. When slot k begins, every output whose index for that sequence equals k is switched. Power up and sleep exit switch outputs on, and power down and sleep entry switch them off. Only outputs selected by a sleep mask take part in the sleep orderings. The slot length comes from two shared 4-bit time settings and one step-multiplier bit.

Level requests control the block. `act_req` asks for the rails to be up, and `slp_req` asks for sleep. A one-cycle `force_shdn_req` pulse powers everything down and then ignores `act_req` for a fixed hold time. A force-active flag is set by reset and can only be cleared by software. While it is set, sleep requests have no effect. The block reports its state and the live level of every enable. It also compares each enable pin's readback with the level it commands, and a mismatch sets a sticky fault that pulls both the interrupt and the reset outputs low.

States and transitions: SHDN goes to PWR_UP when `act_req` is high, no hold is running and no forced shutdown is pending. PWR_UP goes to ACTIVE when its sequence is done. ACTIVE goes to PWR_DN on a low `act_req` or a pending forced shutdown; otherwise it goes to SLP_ENTRY when `slp_req` is high and force-active is clear. SLP_ENTRY goes to SLEEP when done. SLEEP goes to PWR_DN on a low `act_req` or a pending forced shutdown; otherwise it goes to SLP_EXIT when `slp_req` is low. SLP_EXIT goes to ACTIVE when done. PWR_DN goes to SHDN when done.

Top module: `pwr_seq_top`

## Requirements
- R1: After reset, `state_o` is 0 (SHDN), `en_o` is 0, `fault_o` is 0, `irq_n` and `rst_out_n` are 1, and `force_act_o` is 1.
- R2: `state_o` uses this encoding: SHDN=0, PWR_UP=1, PWR_DN=2, SLEEP=3, SLP_ENTRY=4, SLP_EXIT=5, ACTIVE=7. The transitions are the ones listed above.
- R3: In PWR_UP, the slot counter starts at 0 in the cycle after the state is entered. The table index for output i is bits [4i+3:4i] of `up_map`. Output i goes high in the cycle after slot `up_map[i]` starts, and outputs never fall during PWR_UP.
- R4: A slot lasts (units+1) × STEP_CYC cycles, or four times that when `step_long` is 1. PWR_UP and SLP_EXIT use `up_units`, and PWR_DN and SLP_ENTRY use `dn_units`. A sequence ends after slot 15 completes.
- R5: In PWR_DN, output i falls when slot `dn_map[i]` starts, outputs never rise, and SHDN is reached with every output low.
- R6: SLP_ENTRY lowers only the outputs with a 1 in `slp_mask`, each at its `sent_map` slot. SLP_EXIT raises the same outputs, each at its `sext_map` slot. Outputs that are not masked keep their level.
- R7: `force_act_o` is 1 after reset. A `force_act_clr` pulse clears it, and nothing sets it again. While it is 1, `slp_req` has no effect in ACTIVE.
- R8: A change of request during PWR_UP, PWR_DN, SLP_ENTRY or SLP_EXIT does not cut the sequence short. It is acted on once the sequence finishes.
- R9: A `force_shdn_req` pulse causes a power down from ACTIVE or SLEEP, and is held pending if it arrives during another sequence. Once SHDN is reached, `act_req` is ignored for HOLD_CYC cycles.
- R10: A difference between `en_rb` and `en_o` sets `fault_o` one cycle later, provided `en_o` did not change in that cycle. `fault_o` stays set until reset, and `irq_n` and `rst_out_n` are low while it is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| act_req | input | 1 | Level request for rails up |
| slp_req | input | 1 | Level request for sleep |
| force_act_clr | input | 1 | Pulse that clears the force-active flag |
| force_shdn_req | input | 1 | Pulse that requests a forced shutdown with hold |
| up_map | input | 48 | Power-up slot index per output, 4 bits each |
| dn_map | input | 48 | Power-down slot index per output |
| sent_map | input | 48 | Sleep-entry slot index per output |
| sext_map | input | 48 | Sleep-exit slot index per output |
| slp_mask | input | 12 | Outputs that are switched off in sleep |
| up_units | input | 4 | Slot-time setting for power up and sleep exit |
| dn_units | input | 4 | Slot-time setting for power down and sleep entry |
| step_long | input | 1 | Base step: 0 gives STEP_CYC, 1 gives 4×STEP_CYC |
| en_rb | input | 12 | Readback level of each enable pin |
| en_o | output | 12 | Commanded enable levels (live drive status) |
| state_o | output | 3 | Current sequencer state |
| force_act_o | output | 1 | Force-active flag |
| fault_o | output | 1 | Sticky readback fault |
| irq_n | output | 1 | Interrupt, low while a fault is held |
| rst_out_n | output | 1 | Reset request, low while a fault is held |

## Verification
A slot counter that is off by one shows up at `en_o` within one slot length. The output for that slot switches one slot early or late, and the sequence ends a full slot away from the expected cycle, so `state_o` is also wrong. A state register that leaves a sequence early shows at `state_o` before the next slot boundary, and the per-output pattern in `en_o` is left unfinished. A wrong hold or force-active flag shows as a power up or a sleep entry that starts when the stimulus says it must not. A readback fault that is not held shows in `irq_n` once the mismatch is removed.

// File: rtl/pseq_pkg.sv
package pseq_pkg;

    typedef enum logic [2:0] {
        ST_SHDN  = 3'd0,
        ST_UP    = 3'd1,
        ST_DN    = 3'd2,
        ST_SLEEP = 3'd3,
        ST_SENT  = 3'd4,
        ST_SEXT  = 3'd5,
        ST_ACT   = 3'd7
    } pseq_st_e;

endpackage

// File: rtl/pseq_slot_match.sv
module pseq_slot_match #(
    parameter int N_EN   = 12,
    parameter int SLOT_W = 4
) (
    input  logic [N_EN*SLOT_W-1:0] map,
    input  logic [SLOT_W-1:0]      slot,
    output logic [N_EN-1:0]        hit
);

    for (genvar i = 0; i < N_EN; i++) begin : g_cmp
        assign hit[i] = (map[i*SLOT_W +: SLOT_W] == slot);
    end

endmodule

// File: rtl/pseq_slot_timer.sv
module pseq_slot_timer #(
    parameter int SLOT_W   = 4,
    parameter int TIME_W   = 4,
    parameter int STEP_CYC = 12500
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              run,
    input  logic [TIME_W-1:0] units,
    input  logic              step_long,
    output logic [SLOT_W-1:0] slot,
    output logic              slot_start,
    output logic              done
);

    localparam int MAX_LEN = (1 << TIME_W) * 4 * STEP_CYC;
    localparam int LEN_W   = $clog2(MAX_LEN + 1);
    localparam logic [SLOT_W-1:0] LAST_SLOT = '1;

    logic [LEN_W-1:0]  len;
    logic [LEN_W-1:0]  tick_q;
    logic [SLOT_W-1:0] slot_q;
    logic              last_tick;

    always_comb begin
        int unsigned l;
        l   = (int'(units) + 1) * (step_long ? 4 : 1) * STEP_CYC;
        len = LEN_W'(l);
    end

    assign last_tick  = (tick_q == len - LEN_W'(1));
    assign slot       = slot_q;
    assign slot_start = run && (tick_q == '0);
    assign done       = run && last_tick && (slot_q == LAST_SLOT);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tick_q <= '0;
            slot_q <= '0;
        end else if (clr) begin
            tick_q <= '0;
            slot_q <= '0;
        end else if (run) begin
            if (last_tick) begin
                tick_q <= '0;
                if (slot_q != LAST_SLOT) slot_q <= slot_q + SLOT_W'(1);
            end else begin
                tick_q <= tick_q + LEN_W'(1);
            end
        end
    end

    // R4: inside a slot the slot index holds until the last tick
    a_r4_slot_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (run && !clr && !last_tick) |=> (slot_q == $past(slot_q)));

endmodule

// File: rtl/pseq_rb_mon.sv
module pseq_rb_mon #(
    parameter int N_EN = 12
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [N_EN-1:0] en_cmd,
    input  logic [N_EN-1:0] en_rb,
    output logic            fault
);

    logic [N_EN-1:0] en_prev;
    logic            mismatch;

    assign mismatch = (en_prev == en_cmd) && (en_rb != en_cmd);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_prev <= '0;
            fault   <= 1'b0;
        end else begin
            en_prev <= en_cmd;
            if (mismatch) fault <= 1'b1;
        end
    end

    a_r10_fault_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        fault |=> fault);

endmodule

// File: rtl/pwr_seq_top.sv
module pwr_seq_top
    import pseq_pkg::*;
#(
    parameter int N_EN           = 12,
    parameter int SLOT_W         = 4,
    parameter int TIME_W         = 4,
    parameter int STEP_CYC       = 12500,
    parameter int HOLD_CYC       = 500000,
    parameter bit FORCE_ACT_INIT = 1'b1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   act_req,
    input  logic                   slp_req,
    input  logic                   force_act_clr,
    input  logic                   force_shdn_req,
    input  logic [N_EN*SLOT_W-1:0] up_map,
    input  logic [N_EN*SLOT_W-1:0] dn_map,
    input  logic [N_EN*SLOT_W-1:0] sent_map,
    input  logic [N_EN*SLOT_W-1:0] sext_map,
    input  logic [N_EN-1:0]        slp_mask,
    input  logic [TIME_W-1:0]      up_units,
    input  logic [TIME_W-1:0]      dn_units,
    input  logic                   step_long,
    input  logic [N_EN-1:0]        en_rb,
    output logic [N_EN-1:0]        en_o,
    output logic [2:0]             state_o,
    output logic                   force_act_o,
    output logic                   fault_o,
    output logic                   irq_n,
    output logic                   rst_out_n
);

    localparam int HOLD_W = $clog2(HOLD_CYC + 1);

    pseq_st_e              state_q, state_d;
    logic [N_EN-1:0]       en_q;
    logic                  fa_q;
    logic                  force_pend;
    logic [HOLD_W-1:0]     hold_cnt;
    logic                  seq_run, seq_clr, seq_done, slot_start;
    logic [SLOT_W-1:0]     slot;
    logic [TIME_W-1:0]     units;
    logic [N_EN*SLOT_W-1:0] map_sel;
    logic [N_EN-1:0]       hit;
    logic                  consume;
    logic                  down_req;
    logic                  fault;

    // ---------------- sequence engine ----------------
    assign seq_run = (state_q == ST_UP) || (state_q == ST_DN) ||
                     (state_q == ST_SENT) || (state_q == ST_SEXT);
    assign seq_clr = (state_d != state_q);
    assign units   = ((state_q == ST_UP) || (state_q == ST_SEXT)) ? up_units : dn_units;

    always_comb begin
        unique case (state_q)
            ST_UP:   map_sel = up_map;
            ST_DN:   map_sel = dn_map;
            ST_SENT: map_sel = sent_map;
            ST_SEXT: map_sel = sext_map;
            default: map_sel = up_map;
        endcase
    end

    pseq_slot_timer #(
        .SLOT_W  (SLOT_W),
        .TIME_W  (TIME_W),
        .STEP_CYC(STEP_CYC)
    ) i_timer (
        .clk       (clk),
        .rst_n     (rst_n),
        .clr       (seq_clr),
        .run       (seq_run),
        .units     (units),
        .step_long (step_long),
        .slot      (slot),
        .slot_start(slot_start),
        .done      (seq_done)
    );

    pseq_slot_match #(
        .N_EN  (N_EN),
        .SLOT_W(SLOT_W)
    ) i_match (
        .map (map_sel),
        .slot(slot),
        .hit (hit)
    );

    // ---------------- request flags ----------------
    assign consume  = ((state_q == ST_DN) && seq_done) || (state_q == ST_SHDN);
    assign down_req = force_pend || !act_req;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fa_q       <= FORCE_ACT_INIT;
            force_pend <= 1'b0;
            hold_cnt   <= '0;
        end else begin
            if (force_act_clr) fa_q <= 1'b0;
            force_pend <= force_shdn_req || (force_pend && !consume);
            if (consume && force_pend)
                hold_cnt <= HOLD_W'(HOLD_CYC);
            else if ((state_q == ST_SHDN) && (hold_cnt != '0))
                hold_cnt <= hold_cnt - HOLD_W'(1);
        end
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_SHDN;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_SHDN:  if (act_req && !force_pend && (hold_cnt == '0)) state_d = ST_UP;
            ST_UP:    if (seq_done) state_d = ST_ACT;
            ST_ACT: begin
                if (down_req)              state_d = ST_DN;
                else if (slp_req && !fa_q) state_d = ST_SENT;
            end
            ST_SENT:  if (seq_done) state_d = ST_SLEEP;
            ST_SLEEP: begin
                if (down_req)      state_d = ST_DN;
                else if (!slp_req) state_d = ST_SEXT;
            end
            ST_SEXT:  if (seq_done) state_d = ST_ACT;
            ST_DN:    if (seq_done) state_d = ST_SHDN;
            default:  state_d = ST_SHDN;
        endcase
    end

    // ---------------- output process ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= '0;
        end else if (slot_start) begin
            unique case (state_q)
                ST_UP:   en_q <= en_q | hit;
                ST_SEXT: en_q <= en_q | (hit & slp_mask);
                ST_DN:   en_q <= en_q & ~hit;
                ST_SENT: en_q <= en_q & ~(hit & slp_mask);
                default: en_q <= en_q;
            endcase
        end
    end

    pseq_rb_mon #(
        .N_EN(N_EN)
    ) i_rb (
        .clk   (clk),
        .rst_n (rst_n),
        .en_cmd(en_q),
        .en_rb (en_rb),
        .fault (fault)
    );

    assign en_o        = en_q;
    assign state_o     = state_q;
    assign force_act_o = fa_q;
    assign fault_o     = fault;
    assign irq_n       = !fault;
    assign rst_out_n   = !fault;

    // ---------------- assertions ----------------
    a_r3_up_no_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_UP) |=> ((en_q & $past(en_q)) == $past(en_q)));

    a_r5_down_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_DN) |=> ((en_q & ~$past(en_q)) == '0));

    a_r5_shdn_all_low: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SHDN) |-> (en_q == '0));

    a_r7_fa_never_sets: assert property (@(posedge clk) disable iff (!rst_n)
        !fa_q |=> !fa_q);

    a_r8_up_runs_out: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_UP) && !seq_done) |=> (state_q == ST_UP));

    a_r8_dn_runs_out: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_DN) && !seq_done) |=> (state_q == ST_DN));

    a_r9_hold_in_shdn: assert property (@(posedge clk) disable iff (!rst_n)
        ((state_q == ST_SHDN) && (hold_cnt != '0)) |=> (state_q == ST_SHDN));

endmodule

// File: tb/test_pwr_seq_top.sv
module test_pwr_seq_top;

    localparam int N_EN = 12;
    localparam int SW   = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic act_req = 1'b0, slp_req = 1'b0, force_act_clr = 1'b0, force_shdn_req = 1'b0;
    logic [N_EN*SW-1:0] up_map, dn_map, sent_map, sext_map;
    logic [N_EN-1:0] slp_mask = 12'hF00;
    logic [3:0] up_units = 4'd0, dn_units = 4'd0;
    logic step_long = 1'b0;
    logic [N_EN-1:0] rb_flip = '0;
    logic [N_EN-1:0] en_rb, en_o;
    logic [2:0] state_o;
    logic force_act_o, fault_o, irq_n, rst_out_n;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #10 clk = ~clk;  // 50 MHz

    assign en_rb = en_o ^ rb_flip;

    pwr_seq_top #(
        .N_EN(N_EN), .SLOT_W(SW), .TIME_W(4),
        .STEP_CYC(2), .HOLD_CYC(20), .FORCE_ACT_INIT(1'b1)
    ) i_pwr_seq_top (
        .clk(clk), .rst_n(rst_n), .act_req(act_req), .slp_req(slp_req),
        .force_act_clr(force_act_clr), .force_shdn_req(force_shdn_req),
        .up_map(up_map), .dn_map(dn_map), .sent_map(sent_map), .sext_map(sext_map),
        .slp_mask(slp_mask), .up_units(up_units), .dn_units(dn_units),
        .step_long(step_long), .en_rb(en_rb), .en_o(en_o), .state_o(state_o),
        .force_act_o(force_act_o), .fault_o(fault_o), .irq_n(irq_n), .rst_out_n(rst_out_n)
    );

    typedef struct packed {
        logic       act;
        logic       slp;
        logic       fa_clr;
        logic [7:0] wait_n;
        logic [2:0] st;
        logic [11:0] en;
    } vec_t;

    localparam int NV = 9;
    localparam vec_t VEC [NV] = '{
        '{1'b1, 1'b0, 1'b0, 8'd5,  3'd1, 12'h003},  // R3 mid power-up
        '{1'b1, 1'b0, 1'b0, 8'd35, 3'd7, 12'hFFF},  // R2 R3 active
        '{1'b1, 1'b1, 1'b0, 8'd40, 3'd7, 12'hFFF},  // R7 sleep ignored
        '{1'b1, 1'b1, 1'b1, 8'd4,  3'd4, 12'hEFF},  // R6 sleep entry slot 0
        '{1'b1, 1'b1, 1'b0, 8'd36, 3'd3, 12'h0FF},  // R6 sleep
        '{1'b1, 1'b0, 1'b0, 8'd4,  3'd5, 12'hFFF},  // R6 sleep exit
        '{1'b0, 1'b0, 1'b0, 8'd10, 3'd5, 12'hFFF},  // R8 request held
        '{1'b0, 1'b0, 1'b0, 8'd22, 3'd2, 12'h7FF},  // R5 down slot 0
        '{1'b0, 1'b0, 1'b0, 8'd40, 3'd0, 12'h000}   // R5 shutdown
    };

    task automatic check(input string req, input logic [31:0] act_v, input logic [31:0] exp_v);
        n_chk++;
        if (act_v !== exp_v) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act_v, exp_v);
        end
    endtask

    task automatic wait_n(input int n);
        for (int k = 0; k < n; k++) @(negedge clk);
    endtask

    initial begin
        for (int i = 0; i < N_EN; i++) begin
            up_map[i*SW +: SW]   = SW'(i);
            dn_map[i*SW +: SW]   = SW'(11 - i);
            sent_map[i*SW +: SW] = SW'(i % 4);
            sext_map[i*SW +: SW] = SW'(0);
        end
        wait_n(3);
        // R1 reset state
        check("R1 state", 32'(state_o), 32'd0);
        check("R1 en", 32'(en_o), 32'd0);
        check("R1 irq_n/rst_out_n/fault", {29'd0, irq_n, rst_out_n, fault_o}, 32'b110);
        check("R1 force_act", 32'(force_act_o), 32'd1);
        rst_n = 1'b1;
        wait_n(2);

        for (int v = 0; v < NV; v++) begin
            act_req = VEC[v].act;
            slp_req = VEC[v].slp;
            force_act_clr = VEC[v].fa_clr;
            for (int k = 0; k < int'(VEC[v].wait_n); k++) begin
                @(negedge clk);
                force_act_clr = 1'b0;
            end
            check($sformatf("R2 vec%0d state", v), 32'(state_o), 32'(VEC[v].st));
            check($sformatf("R3 R5 R6 vec%0d en", v), 32'(en_o), 32'(VEC[v].en));
        end
        check("R7 force_act cleared", 32'(force_act_o), 32'd0);
        check("R10 no fault on clean readback", 32'(fault_o), 32'd0);

        // R9 forced shutdown with hold
        act_req = 1'b1;
        wait_n(40);
        check("R9 active before force", 32'(state_o), 32'd7);
        force_shdn_req = 1'b1;
        wait_n(1);
        force_shdn_req = 1'b0;
        wait_n(39);
        check("R9 held in shutdown", 32'(state_o), 32'd0);
        check("R9 outputs low in hold", 32'(en_o), 32'd0);
        wait_n(30);
        check("R9 power up after hold", 32'(state_o), 32'd1);
        wait_n(40);
        check("R9 active again", 32'(state_o), 32'd7);

        // R10 readback mismatch
        rb_flip = 12'h008;
        wait_n(2);
        check("R10 fault set", 32'(fault_o), 32'd1);
        check("R10 irq_n/rst_out_n low", {30'd0, irq_n, rst_out_n}, 32'd0);
        rb_flip = '0;
        wait_n(5);
        check("R10 fault sticky", 32'(fault_o), 32'd1);

        // R4 slot length with step multiplier
        act_req = 1'b0;
        wait_n(40);
        check("R4 back in shutdown", 32'(state_o), 32'd0);
        up_units = 4'd1;
        step_long = 1'b1;
        act_req = 1'b1;
        wait_n(17);
        check("R4 slot 1 not yet", 32'(en_o), 32'h001);
        wait_n(1);
        check("R4 slot 1 at 16 cycles", 32'(en_o), 32'h003);
        wait_n(260);
        check("R4 long sequence done", 32'(state_o), 32'd7);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

endmodule